// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a free-running up-counter that produces one pulse waveform on a single output pin. Two programmable values shape the waveform. The period value sets the number of count ticks in one cycle. The compare value sets where in the cycle the pin leaves its idle level. A polarity bit chooses the idle level. On every period match the block raises a single-cycle interrupt strobe. The counter advances only on clock cycles where an external prescaled tick input is high.

Software programs the block through a small write port with three targets: the period, the compare value and a control word. The control word holds the run bit, a one-shot select, the polarity and a double-buffer enable. In continuous operation the waveform repeats until software clears the run bit. In one-shot operation the block clears its own run bit at the end of the current cycle. With double buffering enabled, new period and compare values written while the timer runs are held in shadow copies. They reach the counter logic only at the next period match, so a running cycle is never cut short or stretched by a write.

Top module: `ppg_timer`

## Requirements
- R1: Writing the control word with run (bit 0) = 1 while stopped clears the count to 0 and drives the pin to the polarity level. While running, the count rises by one only on cycles where `tick` is 1, and it holds otherwise.
- R2: When a tick brings the count to the compare value, the pin changes to the inverse of the polarity level on the following clock edge.
- R3: When a tick brings the count to the period value, the count returns to 0 and the pin returns to the polarity level. One cycle therefore lasts `period` ticks, and the pin spends `period - compare` of those ticks away from the idle level.
- R4: Each period match raises `irq` for exactly one clock cycle. `irq` is never high unless the timer was running.
- R5: With one-shot (control bit 1) = 0, the timer keeps running across period matches.
- R6: With one-shot = 1, a period match clears the run bit and the timer stops with the pin at the polarity level.
- R7: A control write that clears the run bit stops the timer, and the pin shows the polarity level after that clock edge.
- R8: The one-shot bit can be written while running. Clearing it cancels the pending stop. Setting it stops the timer at the end of the current cycle.
- R9: With double buffering (control bit 3) = 1 and the timer running, period (select 0) and compare (select 1) writes take effect only at the next period match. In every other case they take effect at once.
- R10: If a period written directly is at or below the current count, the counter passes 0xFFFF, wraps to 0 and matches on the following pass.
- R11: While the run bit is 1, control writes leave polarity (bit 2) and double buffering (bit 3) unchanged.
- R12: While stopped, the pin equals the polarity bit. After reset the pin is 0, `irq` is 0 and `run` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Count enable from the prescaled source clock |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Write target: 0 period, 1 compare, 2 control |
| wr_data | input | CNT_W | Write data. For the control word: bit 0 run, bit 1 one-shot, bit 2 polarity, bit 3 double buffer |
| pin | output | 1 | Pulse output |
| irq | output | 1 | One-cycle strobe on each period match |
| run | output | 1 | Current run bit |

## Verification
The hidden state of this block is the count, the active and shadow values and the control bits. Any error in them shows at the ports as a pin edge or `irq` strobe in the wrong cycle. An error in the count or the compare path moves the next pin edge at once. An error in the period or shadow path moves the next `irq` and the stop of a one-shot run within one period. A lost polarity or run bit shows on the pin on the very next edge after a stop. A reference model in the bench predicts `pin`, `irq` and `run` for every cycle, so any such error is caught in the first cycle where the outputs differ.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CTRL    = 2'd2
  } wsel_e;

  localparam int unsigned CF_RUN     = 0;
  localparam int unsigned CF_ONESHOT = 1;
  localparam int unsigned CF_POL     = 2;
  localparam int unsigned CF_DBUF    = 3;
  localparam int unsigned CF_WIDTH   = 4;

  typedef struct packed {
    logic dbuf;
    logic pol;
    logic oneshot;
    logic run;
  } ctl_t;

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  ctl_t wr_ctl,
  input  logic per_hit,
  output logic run_q,
  output logic run_nxt,
  output logic oneshot_q,
  output logic pol_q,
  output logic pol_nxt,
  output logic dbuf_q,
  output logic start
);

  logic oneshot_d;
  logic dbuf_d;

  always_comb begin
    run_nxt   = run_q;
    oneshot_d = oneshot_q;
    pol_nxt   = pol_q;
    dbuf_d    = dbuf_q;
    if (ctl_wr) begin
      run_nxt   = wr_ctl.run;
      oneshot_d = wr_ctl.oneshot;
      if (!run_q) begin
        pol_nxt = wr_ctl.pol;
        dbuf_d  = wr_ctl.dbuf;
      end
    end else if (per_hit && oneshot_q) begin
      run_nxt = 1'b0;
    end
  end

  assign start = ctl_wr & wr_ctl.run & ~run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
      pol_q     <= 1'b0;
      dbuf_q    <= 1'b0;
    end else begin
      run_q     <= run_nxt;
      oneshot_q <= oneshot_d;
      pol_q     <= pol_nxt;
      dbuf_q    <= dbuf_d;
    end
  end

  // R6: a one-shot period match with no control write stops the timer
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && oneshot_q && !ctl_wr) |=> !run_q)
    else $error("one-shot period match did not clear run");

  // R11: locked fields stay put while running
  p_locked_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ctl_wr) |=> ($stable(pol_q) && $stable(dbuf_q)))
    else $error("polarity or buffer mode changed while running");

endmodule

// File: rtl/ppg_regfile.sv
module ppg_regfile
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dbuf_q,
  input  logic             run_q,
  input  logic             per_hit,
  output logic [CNT_W-1:0] period_act,
  output logic [CNT_W-1:0] compare_act
);

  localparam int unsigned NREG = 2;

  logic                      direct;
  logic [NREG-1:0][CNT_W-1:0] act_q, act_d;
  logic [NREG-1:0][CNT_W-1:0] shd_q, shd_d;

  assign direct = ~(dbuf_q & run_q);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_wr;
    assign hit_wr = wr_en & (wr_sel == 2'(g));

    always_comb begin
      shd_d[g] = shd_q[g];
      act_d[g] = act_q[g];
      if (hit_wr) shd_d[g] = wr_data;
      if (hit_wr && direct) act_d[g] = wr_data;
      else if (per_hit)     act_d[g] = shd_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        shd_q[g] <= shd_d[g];
        act_q[g] <= act_d[g];
      end
    end
  end

  assign period_act  = act_q[SEL_PERIOD];
  assign compare_act = act_q[SEL_COMPARE];

  // R9: buffered values only move on a period match
  p_dbuf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_q && run_q && !per_hit) |=> ($stable(period_act) && $stable(compare_act)))
    else $error("active value changed outside a period match with buffering on");

endmodule

// File: rtl/ppg_count.sv
module ppg_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] period_act,
  input  logic [CNT_W-1:0] compare_act,
  output logic             per_hit,
  output logic             cmp_hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             adv;

  assign adv     = run_q & tick;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign per_hit = adv & (cnt_inc == period_act);
  assign cmp_hit = adv & (cnt_inc == compare_act);

  always_comb begin
    cnt_d = cnt_q;
    if (start)        cnt_d = '0;
    else if (per_hit) cnt_d = '0;
    else if (adv)     cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: no tick and no start leaves the count untouched
  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(cnt_q))
    else $error("count moved without a tick");

endmodule

// File: rtl/ppg_outff.sv
module ppg_outff (
  input  logic clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic run_nxt,
  input  logic start,
  input  logic per_hit,
  input  logic cmp_hit,
  input  logic pol_q,
  input  logic pol_nxt,
  output logic pin_q,
  output logic irq_q
);

  logic pin_d;

  always_comb begin
    if (!run_nxt || start) pin_d = pol_nxt;
    else if (per_hit)      pin_d = pol_q;
    else if (cmp_hit)      pin_d = ~pol_q;
    else                   pin_d = pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      irq_q <= per_hit;
    end
  end

  // R7 / R12: a stopped timer shows the idle level
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pin_q == pol_q))
    else $error("pin not at idle level while stopped");

  // R4: strobe only follows a running cycle
  p_irq_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(run_q))
    else $error("irq without running timer");

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pin,
  output logic             irq,
  output logic             run
);

  logic             rst_meta, rst_sync_n;
  logic             ctl_wr;
  ctl_t             wr_ctl;
  logic             run_q, run_nxt, oneshot_q, pol_q, pol_nxt, dbuf_q, start;
  logic             per_hit, cmp_hit;
  logic [CNT_W-1:0] period_act, compare_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign ctl_wr         = wr_en & (wr_sel == SEL_CTRL);
  assign wr_ctl.run     = wr_data[CF_RUN];
  assign wr_ctl.oneshot = wr_data[CF_ONESHOT];
  assign wr_ctl.pol     = wr_data[CF_POL];
  assign wr_ctl.dbuf    = wr_data[CF_DBUF];

  ppg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl_wr    (ctl_wr),
    .wr_ctl    (wr_ctl),
    .per_hit   (per_hit),
    .run_q     (run_q),
    .run_nxt   (run_nxt),
    .oneshot_q (oneshot_q),
    .pol_q     (pol_q),
    .pol_nxt   (pol_nxt),
    .dbuf_q    (dbuf_q),
    .start     (start)
  );

  ppg_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .dbuf_q      (dbuf_q),
    .run_q       (run_q),
    .per_hit     (per_hit),
    .period_act  (period_act),
    .compare_act (compare_act)
  );

  ppg_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run_q       (run_q),
    .tick        (tick),
    .start       (start),
    .period_act  (period_act),
    .compare_act (compare_act),
    .per_hit     (per_hit),
    .cmp_hit     (cmp_hit)
  );

  ppg_outff u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_q   (run_q),
    .run_nxt (run_nxt),
    .start   (start),
    .per_hit (per_hit),
    .cmp_hit (cmp_hit),
    .pol_q   (pol_q),
    .pol_nxt (pol_nxt),
    .pin_q   (pin),
    .irq_q   (irq)
  );

  assign run = run_q;

endmodule

// File: tb/ppg_timer_test.sv
module ppg_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [1:0] S_PER = 2'd0, S_CMP = 2'd1, S_CTL = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic pin, irq, run;

  int n_tests = 0, n_fail = 0;

  logic m_run, m_os, m_pol, m_db, m_pin, m_irq;
  logic [W-1:0] m_cnt, m_pa, m_ca, m_ps, m_cs;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppg_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pin(pin), .irq(irq), .run(run)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ctl(input bit r, input bit os, input bit p, input bit db);
    return W'({db, p, os, r});
  endfunction

  task automatic model_step(input logic t, input logic w, input logic [1:0] s, input logic [W-1:0] d);
    logic cw, st, ph, chh, direct, rn, pn;
    logic [W-1:0] nx;
    cw = w && s == S_CTL;
    st = cw && d[0] && !m_run;
    nx = m_cnt + 16'd1;
    ph = m_run && t && nx == m_pa;
    chh = m_run && t && nx == m_ca;
    direct = !(m_db && m_run);
    rn = cw ? d[0] : ((ph && m_os) ? 1'b0 : m_run);
    pn = (cw && !m_run) ? d[2] : m_pol;
    if (!rn || st) m_pin = pn;
    else if (ph) m_pin = m_pol;
    else if (chh) m_pin = ~m_pol;
    m_irq = ph;
    if (st || ph) m_cnt = '0;
    else if (m_run && t) m_cnt = nx;
    if (w && s == S_PER && direct) m_pa = d; else if (ph) m_pa = m_ps;
    if (w && s == S_CMP && direct) m_ca = d; else if (ph) m_ca = m_cs;
    if (w && s == S_PER) m_ps = d;
    if (w && s == S_CMP) m_cs = d;
    if (cw) begin
      m_os = d[1];
      if (!m_run) m_db = d[3];
    end
    m_pol = pn;
    m_run = rn;
  endtask

  task automatic cyc(input logic t, input logic w, input logic [1:0] s, input logic [W-1:0] d);
    tick = t; wr_en = w; wr_sel = s; wr_data = d;
    model_step(t, w, s, d);
    @(posedge clk);
    @(negedge clk);
    chk({pin, irq, run} === {m_pin, m_irq, m_run}, "model", {pin, irq, run}, {m_pin, m_irq, m_run});
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d, input logic t = 1'b0);
    cyc(t, 1'b1, s, d);
  endtask

  task automatic ticks(input int n, input logic t = 1'b1);
    for (int i = 0; i < n; i++) cyc(t, 1'b0, 2'd0, '0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int irqs, highs, idx, idx2, p21, p22;
    {m_run, m_os, m_pol, m_db, m_pin, m_irq} = '0;
    {m_cnt, m_pa, m_ca, m_ps, m_cs} = '0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(pin === 1'b0, "R12 reset pin", pin, 0);
    chk(irq === 1'b0, "R12 reset irq", irq, 0);
    chk(run === 1'b0, "R12 reset run", run, 0);

    // R12 polarity sets the idle level while stopped
    wr(S_CTL, ctl(0, 0, 1, 0));
    chk(pin === 1'b1, "R12 idle high", pin, 1);
    wr(S_CTL, ctl(0, 0, 0, 0));
    chk(pin === 1'b0, "R12 idle low", pin, 0);

    // R1 R2 R3 R4 R5 continuous, period 10 compare 4
    wr(S_PER, 16'd10); wr(S_CMP, 16'd4); wr(S_CTL, ctl(1, 0, 0, 0));
    chk(run === 1'b1 && pin === 1'b0, "R1 start", {run, pin}, 2);
    irqs = 0; highs = 0;
    for (int i = 0; i < 30; i++) begin
      ticks(1);
      irqs += int'(irq); highs += int'(pin);
    end
    chk(irqs == 3, "R4 irq count", irqs, 3);
    chk(highs == 18, "R2 R3 high ticks", highs, 18);
    chk(run === 1'b1, "R5 still running", run, 1);

    // R1 no ticks, then every other cycle
    irqs = 0;
    for (int i = 0; i < 20; i++) begin ticks(1, 1'b0); irqs += int'(irq); end
    chk(irqs == 0 && pin === 1'b0, "R1 hold without tick", irqs, 0);
    irqs = 0; idx = 0;
    for (int i = 1; i <= 20; i++) begin
      ticks(1, (i % 2) == 1);
      if (irq) begin irqs++; idx = i; end
    end
    chk(idx == 19, "R1 sparse ticks irq cycle", idx, 19);
    chk(irqs == 1, "R4 sparse irq count", irqs, 1);

    // R7 software stop with pin away from idle
    ticks(5);
    chk(pin === 1'b1, "R2 pin active", pin, 1);
    wr(S_CTL, ctl(0, 0, 0, 0));
    chk(pin === 1'b0 && run === 1'b0, "R7 stop returns pin", {pin, run}, 0);

    // R6 one-shot with polarity 1
    wr(S_CTL, ctl(1, 1, 1, 0));
    ticks(9);
    chk(pin === 1'b0 && run === 1'b1, "R2 inverted active", {pin, run}, 1);
    ticks(1);
    chk({run, irq, pin} === 3'b011, "R6 auto stop", {run, irq, pin}, 3);
    irqs = 0;
    for (int i = 0; i < 15; i++) begin ticks(1); irqs += int'(irq); end
    chk(irqs == 0 && pin === 1'b1, "R6 stays stopped", irqs, 0);
    wr(S_CTL, ctl(0, 0, 0, 0));

    // R8 continuous to one-shot while running
    wr(S_CTL, ctl(1, 0, 0, 0));
    ticks(3);
    wr(S_CTL, ctl(1, 1, 0, 0), 1'b1);
    idx = 0; irqs = 0;
    for (int i = 1; i <= 20; i++) begin
      ticks(1);
      irqs += int'(irq);
      if (idx == 0 && run === 1'b0) idx = i;
    end
    chk(idx == 6, "R8 stop after current pulse", idx, 6);
    chk(irqs == 1, "R8 single irq", irqs, 1);

    // R8 one-shot to continuous cancels stop
    wr(S_CTL, ctl(1, 1, 0, 0));
    ticks(5);
    wr(S_CTL, ctl(1, 0, 0, 0), 1'b1);
    irqs = 0;
    for (int i = 0; i < 30; i++) begin ticks(1); irqs += int'(irq); end
    chk(irqs == 3 && run === 1'b1, "R8 stop cancelled", irqs, 3);
    wr(S_CTL, ctl(0, 0, 0, 0));

    // R9 double buffer
    wr(S_CTL, ctl(0, 0, 0, 1));
    wr(S_PER, 16'd10); wr(S_CMP, 16'd4);
    wr(S_CTL, ctl(1, 0, 0, 1));
    ticks(3);
    wr(S_PER, 16'd20); wr(S_CMP, 16'd15);
    idx = 0; idx2 = 0; p21 = 0; p22 = 0;
    for (int i = 1; i <= 27; i++) begin
      ticks(1);
      if (irq) begin if (idx == 0) idx = i; else idx2 = i; end
      if (i == 21) p21 = int'(pin);
      if (i == 22) p22 = int'(pin);
    end
    chk(idx == 7, "R9 old period finishes", idx, 7);
    chk(idx2 == 27, "R9 new period applied", idx2, 27);
    chk(p21 == 0 && p22 == 1, "R9 new compare applied", {p21[0], p22[0]}, 1);
    wr(S_CTL, ctl(0, 0, 0, 0));
    wr(S_CTL, ctl(0, 0, 0, 0));

    // R11 locked fields while running
    wr(S_CTL, ctl(1, 0, 0, 0));
    ticks(2);
    wr(S_CTL, ctl(1, 0, 1, 0));
    wr(S_CTL, ctl(0, 0, 1, 0));
    chk(pin === 1'b0, "R11 polarity write ignored", pin, 0);
    wr(S_CTL, ctl(0, 0, 1, 0));
    chk(pin === 1'b1, "R12 polarity accepted when stopped", pin, 1);
    wr(S_CTL, ctl(0, 0, 0, 0));

    // R9 direct write takes effect at once
    wr(S_PER, 16'd10); wr(S_CMP, 16'd4);
    wr(S_CTL, ctl(1, 0, 0, 0));
    ticks(3);
    wr(S_PER, 16'd6);
    idx = 0;
    for (int i = 1; i <= 10; i++) begin ticks(1); if (idx == 0 && irq) idx = i; end
    chk(idx == 3, "R9 direct period", idx, 3);
    wr(S_CTL, ctl(0, 0, 0, 0));

    // R10 period written below the count wraps
    wr(S_PER, 16'd100); wr(S_CMP, 16'd50);
    wr(S_CTL, ctl(1, 0, 0, 0));
    ticks(60);
    wr(S_PER, 16'd30);
    idx = 0;
    for (int i = 1; i <= 70000 && idx == 0; i++) begin ticks(1); if (irq) idx = i; end
    chk(idx == 65506, "R10 wrap before match", idx, 65506);
    wr(S_CTL, ctl(0, 0, 0, 0));

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      logic t, w;
      logic [1:0] s;
      logic [W-1:0] d;
      t = ($urandom % 4) != 0;
      w = ($urandom % 16) == 0;
      s = 2'($urandom % 3);
      case (s)
        S_PER:   d = m_cnt + 16'd2 + 16'($urandom % 30);
        S_CMP:   d = 16'($urandom % 30);
        default: d = ctl(($urandom % 5) != 0, ($urandom % 4) == 0, $urandom % 2, $urandom % 2);
      endcase
      cyc(t, w, s, d);
    end

    finish_run();
  end

endmodule